// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address sequence of one SDRAM read or write burst, one address per clock. A configuration word, captured on a load strobe, selects the burst length, the address ordering, the read latency and a write mode in which writes are forced to one beat. Each word is checked before it is accepted. A word that breaks any rule is dropped, the settings already in force stay, and a sticky error flag is raised.

A start strobe supplies the first column and the transfer direction. From the next clock on, the block drives a column, a valid flag, a direction flag and a last-beat flag. This continues until the burst completes, a stop input cuts it short, or a new start strobe replaces it.

The ordering wraps inside an aligned block of the burst length. The bits of the column above that block stay at their start values. In full-page mode the whole 8-bit column space is walked until a stop arrives. The read latency and the single-write mode are presented as static outputs for the data path.

Top module: `sdram_col_seq`

## Requirements
- R1: Word bits [2:0] set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page. Codes 100, 101 and 110 are rejected.
- R2: With word bit 3 = 0 (sequential), beat k is at column (start + k) taken modulo the burst length within the aligned block. Start 2 with length 4 gives 2,3,0,1. Start 5 with length 8 gives 5,6,7,0,1,2,3,4.
- R3: With word bit 3 = 1 (interleaved), beat k has low bits equal to (start XOR k) over the low log2(length) bits. Start 3 with length 8 gives 3,2,1,0,7,6,5,4.
- R4: In full-page mode the column counts up from the start modulo 256 with no last flag, until a stop input ends the burst.
- R5: Column bits above the wrap field hold their start value for every beat of a non-full-page burst.
- R6: Word bits [6:4] set the read latency reported on rd_lat_o: 001 gives 1, 010 gives 2, 011 gives 3. Every other code is rejected.
- R7: When word bit 9 is set, wr_single_o is 1 and every write burst is one beat with the last flag set, while read bursts use the programmed length.
- R8: A word is rejected if any of bits 7, 8, 10, 11, 12 or 13 is 1, or if full page is combined with interleaved ordering. Bits 13:12 are the bank-select bits.
- R9: A rejected word leaves length, ordering, latency and write mode unchanged, and sets mode_err_o. Only reset clears mode_err_o.
- R10: The first beat appears in the cycle after the clock edge that samples start_i, and one beat follows per clock. col_last_o is 1 exactly on the final beat, and col_valid_o is 0 in the following cycle. col_wr_o follows the direction given at start.
- R11: stop_i sampled during a burst ends it: col_valid_o is 0 from the next cycle.
- R12: start_i sampled during a burst abandons it, and the next cycle shows the first beat of the new burst.
- R13: After reset there is no active burst and mode_err_o is 0. The settings are length 1, sequential ordering, read latency 2 and normal writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_load_i | input | 1 | Capture mode_word_i |
| mode_word_i | input | 14 | Configuration word; bits 13:12 are bank-select bits |
| start_i | input | 1 | Begin a burst |
| start_col_i | input | COL_W | First column of the burst |
| start_wr_i | input | 1 | Burst direction, 1 = write |
| stop_i | input | 1 | End the active burst |
| col_o | output | COL_W | Current column address |
| col_valid_o | output | 1 | A beat is presented |
| col_last_o | output | 1 | Final beat of the burst |
| col_wr_o | output | 1 | Direction of the presented beat |
| rd_lat_o | output | 2 | Configured read latency |
| wr_single_o | output | 1 | Writes forced to single beats |
| mode_err_o | output | 1 | Sticky rejected-word flag |

## Verification
The hardest cases to reach from the ports are those where one event arrives in the middle of a burst. A restart or a stop in mid-burst must cut the address walk at the right beat. A full-page walk must cross the 8-bit column boundary before it is stopped. Directed sequences place a restart on the second beat of an 8-beat burst and run a full-page walk over 300 beats. Random bursts with seeded stops land on other beat positions, and random configuration words with a few rejected bit patterns between them check that a bad word never disturbs the next burst.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  localparam int MODE_W = 14;

  typedef struct packed {
    logic [1:0] lg;        // log2 of burst length when not full page
    logic       full;
    logic       ileave;
    logic [1:0] rd_lat;
    logic       wr_single;
  } mode_t;

  localparam mode_t MODE_RST = '{lg: 2'd0, full: 1'b0, ileave: 1'b0,
                                 rd_lat: 2'd2, wr_single: 1'b0};

  function automatic logic mode_ok(input logic [MODE_W-1:0] w);
    logic len_ok, lat_ok, rsv_ok, combo_ok;
    len_ok   = (w[2] == 1'b0) || (w[2:0] == 3'b111);
    lat_ok   = (w[6] == 1'b0) && (w[5:4] != 2'b00);
    rsv_ok   = (w[8:7] == 2'b00) && (w[13:10] == 4'b0000);
    combo_ok = !((w[2:0] == 3'b111) && w[3]);
    return len_ok && lat_ok && rsv_ok && combo_ok;
  endfunction

  function automatic mode_t mode_decode(input logic [MODE_W-1:0] w);
    mode_t m;
    m.full      = (w[2:0] == 3'b111);
    m.lg        = m.full ? 2'd0 : w[1:0];
    m.ileave    = w[3];
    m.rd_lat    = w[5:4];
    m.wr_single = w[9];
    return m;
  endfunction
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_col_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] word_i,
  output mode_t             mode_o,
  output logic              err_o
);
  mode_t mode_q;
  logic  err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      err_q  <= 1'b0;
    end else if (load_i) begin
      if (mode_ok(word_i)) mode_q <= mode_decode(word_i);
      else                 err_q  <= 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;
endmodule

// File: rtl/sdram_col_order.sv
module sdram_col_order #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ileave_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_low, il_low;

  always_comb begin
    seq_low = (start_col_i + beat_i) & mask_i;
    il_low  = (start_col_i ^ beat_i) & mask_i;
    col_o   = (start_col_i & ~mask_i) | (ileave_i ? il_low : seq_low);
  end
endmodule

// File: rtl/sdram_burst_ctl.sv
module sdram_burst_ctl
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_t            mode_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             start_wr_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic             last_o,
  output logic             wr_o,
  output logic             ileave_o,
  output logic [COL_W-1:0] start_col_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             act_q, full_q, il_q, wr_q;
  logic [1:0]       lg_q;
  logic [COL_W-1:0] sc_q, beat_q, mask;
  logic             last, single_wr;

  assign single_wr = start_wr_i && mode_i.wr_single;
  assign mask      = full_q ? '1 : ((ONE << lg_q) - ONE);
  assign last      = act_q && !full_q && (beat_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      il_q   <= 1'b0;
      wr_q   <= 1'b0;
      lg_q   <= 2'd0;
      sc_q   <= '0;
      beat_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      full_q <= single_wr ? 1'b0 : mode_i.full;
      lg_q   <= single_wr ? 2'd0 : mode_i.lg;
      il_q   <= mode_i.ileave;
      wr_q   <= start_wr_i;
      sc_q   <= start_col_i;
      beat_q <= '0;
    end else if (act_q && (stop_i || last)) begin
      act_q  <= 1'b0;
    end else if (act_q) begin
      beat_q <= beat_q + ONE;
    end
  end

  assign active_o    = act_q;
  assign last_o      = last;
  assign wr_o        = act_q && wr_q;
  assign ileave_o    = il_q;
  assign start_col_o = sc_q;
  assign beat_o      = beat_q;
  assign mask_o      = mask;
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              start_wr_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              col_last_o,
  output logic              col_wr_o,
  output logic [1:0]        rd_lat_o,
  output logic              wr_single_o,
  output logic              mode_err_o
);
  mode_t            mode;
  logic             active, il;
  logic [COL_W-1:0] sc, beat, mask, col;

  sdram_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mode_load_i),
    .word_i (mode_word_i),
    .mode_o (mode),
    .err_o  (mode_err_o)
  );

  sdram_burst_ctl #(.COL_W(COL_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .start_wr_i  (start_wr_i),
    .stop_i      (stop_i),
    .active_o    (active),
    .last_o      (col_last_o),
    .wr_o        (col_wr_o),
    .ileave_o    (il),
    .start_col_o (sc),
    .beat_o      (beat),
    .mask_o      (mask)
  );

  sdram_col_order #(.COL_W(COL_W)) u_order (
    .start_col_i (sc),
    .beat_i      (beat),
    .mask_i      (mask),
    .ileave_i    (il),
    .col_o       (col)
  );

  assign col_o       = active ? col : '0;
  assign col_valid_o = active;
  assign rd_lat_o    = mode.rd_lat;
  assign wr_single_o = mode.wr_single;
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_load_i,
  input logic [MODE_W-1:0] mode_word_i,
  input logic              start_i,
  input logic [COL_W-1:0]  start_col_i,
  input logic              start_wr_i,
  input logic              stop_i,
  input logic [COL_W-1:0]  col_o,
  input logic              col_valid_o,
  input logic              col_last_o,
  input logic              col_wr_o,
  input logic [1:0]        rd_lat_o,
  input logic              wr_single_o,
  input logic              mode_err_o
);
  p_last_in_burst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_last_o |-> col_valid_o);

  p_idle_after_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_last_o && !start_i) |=> !col_valid_o);

  p_stop_ends_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !col_valid_o);

  p_first_beat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (col_valid_o && col_o == $past(start_col_i) && col_wr_o == $past(start_wr_i)));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |=> mode_err_o);

  p_bad_word_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_load_i && !mode_ok(mode_word_i)) |=>
      (mode_err_o && $stable(rd_lat_o) && $stable(wr_single_o)));

  p_lat_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lat_o != 2'd0);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_valid_o |-> (!col_last_o && !col_wr_o));
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_sdram_col_seq.sv
module tb_sdram_col_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld = 1'b0;
  logic [13:0] word = '0;
  logic        start = 1'b0;
  logic [7:0]  scol = '0;
  logic        swr = 1'b0;
  logic        stop = 1'b0;
  logic [7:0]  col;
  logic        valid, last, colwr, wsingle, err;
  logic [1:0]  rdlat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench copy of the configuration, kept from the requirement text
  int m_lg = 0, m_lat = 2;
  bit m_full = 0, m_il = 0, m_ws = 0, m_err = 0;

  always #4 clk = ~clk;

  sdram_col_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_load_i(ld), .mode_word_i(word),
    .start_i(start), .start_col_i(scol), .start_wr_i(swr), .stop_i(stop),
    .col_o(col), .col_valid_o(valid), .col_last_o(last), .col_wr_o(colwr),
    .rd_lat_o(rdlat), .wr_single_o(wsingle), .mode_err_o(err)
  );

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit word_good(input logic [13:0] w);
    bit ok = 1;
    case (w[2:0])
      3'b100, 3'b101, 3'b110: ok = 0;
      default: ;
    endcase
    if (w[2:0] == 3'b111 && w[3]) ok = 0;
    if (!(w[6:4] == 3'd1 || w[6:4] == 3'd2 || w[6:4] == 3'd3)) ok = 0;
    if (w[7] || w[8] || w[10] || w[11] || w[12] || w[13]) ok = 0;
    return ok;
  endfunction

  function automatic int exp_col(input int sc, input int b, input int lg, input bit full, input bit il);
    int m;
    if (full) return (sc + b) % 256;
    m = (1 << lg) - 1;
    if (il) return (sc & ~m & 255) | ((sc ^ b) & m);
    return (sc & ~m & 255) | ((sc + b) & m);
  endfunction

  task automatic load(input logic [13:0] w, input string req);
    @(negedge clk); ld = 1; word = w;
    @(negedge clk); ld = 0;
    if (word_good(w)) begin
      m_full = (w[2:0] == 3'b111);
      m_lg   = m_full ? 0 : int'(w[1:0]);
      m_il   = w[3];
      m_lat  = int'(w[6:4]);
      m_ws   = w[9];
    end else m_err = 1;
    chk_eq(req, "rd_lat", rdlat, m_lat);
    chk_eq(req, "wr_single", wsingle, m_ws);
    chk_eq(req, "mode_err", err, m_err);
  endtask

  // stop_after: beats shown before stop is raised (0 = run to natural end)
  task automatic do_burst(input int sc, input bit wr, input int stop_after, input string req);
    int n, lg_e;
    bit full_e, stopped;
    full_e = m_full; lg_e = m_lg;
    if (wr && m_ws) begin full_e = 0; lg_e = 0; end
    n = full_e ? stop_after : (1 << lg_e);
    stopped = full_e;
    if (!full_e && stop_after > 0 && stop_after < n) begin n = stop_after; stopped = 1; end
    @(negedge clk); start = 1; scol = 8'(sc); swr = wr;
    @(negedge clk); start = 0;
    for (int b = 0; b < n; b++) begin
      chk_eq(req, "valid", valid, 1);
      chk_eq(req, "col", col, exp_col(sc, b, lg_e, full_e, m_il));
      chk_eq(req, "last", last, (!stopped && b == n - 1) ? 1 : 0);
      chk_eq(req, "wr", colwr, wr);
      if (stopped && b == n - 1) stop = 1;
      @(negedge clk); stop = 0;
    end
    chk_eq(req, "valid_after_end", valid, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #20 rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk_eq("R13", "valid", valid, 0);
    chk_eq("R13", "last", last, 0);
    chk_eq("R13", "err", err, 0);
    chk_eq("R13", "rd_lat", rdlat, 2);
    chk_eq("R13", "wr_single", wsingle, 0);
    do_burst(8'h37, 0, 0, "R13");

    // R1 length codes
    load(14'h010, "R1"); do_burst(8'h20, 0, 0, "R1");
    load(14'h011, "R1"); do_burst(8'h21, 1, 0, "R1");
    // R2 sequential wrap, R6 latency
    load(14'h012, "R6"); do_burst(2, 0, 0, "R2");
    load(14'h033, "R6"); do_burst(8'hA5, 0, 0, "R5");
    do_burst(5, 1, 0, "R2");
    // R3 interleave
    load(14'h02B, "R3"); do_burst(3, 0, 0, "R3");
    do_burst(8'h73, 0, 0, "R5");
    load(14'h01A, "R3"); do_burst(8'hC1, 0, 0, "R3");
    // R4 full page crossing the top
    load(14'h027, "R4"); do_burst(8'hFE, 0, 5, "R4");
    do_burst(8'h10, 1, 300, "R4");
    // R7 single writes
    load(14'h223, "R7"); do_burst(8'h44, 1, 0, "R7"); do_burst(8'h44, 0, 0, "R7");
    // R1/R8/R9 rejected words keep the 8-beat single-write setting
    load(14'h025, "R1");
    load(14'h02F, "R8");
    load(14'h003, "R6");
    load(14'h0A3, "R8");
    load(14'h1023, "R8");
    load(14'h823, "R8");
    do_burst(8'h09, 0, 0, "R9");
    do_burst(8'h09, 1, 0, "R9");
    // R11 early stop
    load(14'h023, "R11"); do_burst(8'h3C, 0, 3, "R11");
    // R12 restart on second beat
    @(negedge clk); start = 1; scol = 8'h15; swr = 0;
    @(negedge clk); start = 0;
    chk_eq("R12", "col", col, 8'h15);
    @(negedge clk);
    chk_eq("R12", "col", col, 8'h16);
    start = 1; scol = 8'h80; swr = 1;
    @(negedge clk); start = 0;
    for (int b = 0; b < 8; b++) begin
      chk_eq("R12", "col", col, 8'h80 + b);
      chk_eq("R12", "wr", colwr, 1);
      chk_eq("R12", "last", last, (b == 7) ? 1 : 0);
      @(negedge clk);
    end
    chk_eq("R12", "valid_after", valid, 0);

    // random mix
    for (int i = 0; i < 200; i++) begin
      logic [13:0] w;
      int r, bl;
      r = int'($urandom_range(0, 9));
      bl = (r < 5) ? r : ((r < 9) ? int'($urandom_range(0, 3)) : int'($urandom_range(4, 6)));
      if (r == 4) bl = 7;
      w = '0;
      w[2:0] = 3'(bl);
      w[3] = (bl == 7) ? ($urandom_range(0, 9) == 0) : 1'($urandom_range(0, 1));
      w[6:4] = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(1, 3));
      w[9] = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 14) == 0) w[7 + int'($urandom_range(0, 6))] = 1'b1;
      w[9] = w[9];
      load(w, "R9");
      for (int j = 0; j < 3; j++) begin
        int sa;
        sa = int'($urandom_range(0, 12));
        if (m_full && sa == 0) sa = 1;
        if (!m_full && $urandom_range(0, 2) != 0) sa = 0;
        do_burst(int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), sa, m_il ? "R3" : "R2");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_200_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule